// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a supervisory down-counter. Once software enables it and restarts it with a two-write key sequence, it counts prescaled ticks down from a programmable reload value. If the count runs out, or if software breaks the key sequence, the block expires. On expiry it raises either an interrupt or a reset request, as the reset-mode bit selects. A sticky flag records the expiry. The flag survives the system reset that the block itself requests, and only a power-on reset or a software write clears it.

The tick source is chosen from two external tick strobes or from every bus clock cycle. A synchronous tick-enable input can pause the tick. The selected tick passes through a fixed divide-by-four prescaler, so a timeout always lasts a multiple of four source ticks. The reload register never holds less than 0xFF, which makes the shortest timeout 1024 source ticks.

The controller has four states. OFF is left for WAIT when the enable bit is set. WAIT goes to RUN on a valid feed, and to EXPIRED on a broken feed. RUN reloads the count on a valid feed. RUN goes to EXPIRED on a broken feed, or when a prescaled tick arrives while the count is already zero. EXPIRED goes back to RUN on a valid feed, but only in interrupt mode. In reset mode EXPIRED is left only through reset. The feed checker has two states. IDLE moves to ARMED when the first key is written. ARMED returns to IDLE on the next bus access: that access is accepted if it writes the second key and is reported as broken otherwise.

Top module: `wdt_top`

## Requirements
- R1: After reset, the register at address 0 (bit 0 enable, bit 1 reset mode, bit 2 expiry flag, bits 4:3 tick source) reads 0. The reload register (address 1) and the count (address 3) both read 0xFF. The interrupt, reset request and flag are low.
- R2: A value written to the reload register that is below 0xFF is stored as 0xFF. Any other value is stored unchanged.
- R3: The enable bit and the reset-mode bit can be set by writing 1, but writing 0 does not clear them. Only the system reset clears them.
- R4: The count does not change until the enable bit is set and one valid feed has completed.
- R5: A valid feed is a write of 0xAA to address 2 followed directly by a write of 0x55 to address 2, with no other bus access (read or write) between them. A valid feed loads the count from the reload register.
- R6: With an uninterrupted tick, expiry happens exactly 4×(reload+1) ticks after the clock edge of the valid feed. The interrupt is raised when reset mode is off, and the reset request when it is on. The two are never high together.
- R7: While the block is enabled, a broken feed makes it expire at the clock edge of the offending access. A broken feed is any access after 0xAA other than a 0x55 feed write, or any feed write with a value other than 0xAA that does not complete a sequence.
- R8: The expiry flag is set on every expiry. It keeps its value through the system reset. It is cleared by the power-on reset, or by writing 1 to bit 2 of address 0.
- R9: Tick source codes are: 0 for the first tick strobe, 1 for the second, and 2 or 3 for every clock. While tick-enable is low, or while the selected strobe is low, the count does not move.
- R10: In interrupt mode, a valid feed while expired clears the interrupt and restarts counting from the reload value.
- R11: In reset mode, the reset request stays high from expiry until the system reset is applied.
- R12: If a valid feed completes on the same clock edge as the final prescaled tick, the feed wins. No expiry occurs and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| por_n | input | 1 | Power-on reset, active low, clears the expiry flag |
| rst_n | input | 1 | System reset, active low, clears everything except the flag |
| tick_rtc | input | 1 | Tick strobe, source code 0 |
| tick_irc | input | 1 | Tick strobe, source code 1 |
| tick_en | input | 1 | Synchronous tick enable |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on address |
| wdt_irq | output | 1 | Expiry interrupt (level) |
| wdt_rst_req | output | 1 | Expiry reset request (level) |
| wdt_flag | output | 1 | Sticky expiry flag |

## Verification
The interesting collision is a valid feed and the final prescaled tick landing on the same clock edge. The bench measures the first feed and then times the 0x55 write so that it is sampled on exactly the edge where expiry is due. The scoreboard then expects no event at that edge and one a full period later, so an early interrupt is caught as an unexpected or mistimed item. A second collision is between a read and an armed key sequence: the read is the offending access, and the expiry must appear at that read's own edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        S_OFF,
        S_WAIT,
        S_RUN,
        S_EXPIRED
    } wdt_state_e;

    typedef enum logic {
        F_IDLE,
        F_ARMED
    } feed_state_e;

    localparam logic [1:0] A_MODE   = 2'd0;
    localparam logic [1:0] A_RELOAD = 2'd1;
    localparam logic [1:0] A_FEED   = 2'd2;
    localparam logic [1:0] A_COUNT  = 2'd3;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int B_EN    = 0;
    localparam int B_RMODE = 1;
    localparam int B_FLAG  = 2;
    localparam int B_SEL   = 3;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int NSRC  = 2,
    parameter int SEL_W = 2,
    parameter int DIV   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick_en,
    input  logic             run,
    input  logic             clr,
    output logic             pulse
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic sel_tick;
    logic adv;

    // codes below NSRC pick a strobe, the rest tick every clock
    always_comb begin
        sel_tick = 1'b1;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) sel_tick = src_tick[i];
        end
    end

    assign adv = run && tick_en && sel_tick;

    generate
        if (DIV == 1) begin : g_nodiv
            assign pulse = adv;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (clr)
                    div_q <= '0;
                else if (adv)
                    div_q <= (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
            end
            assign pulse = adv && (div_q == DW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/wdt_feed.sv
module wdt_feed
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       access,
    input  logic       feed_wr,
    input  logic [7:0] key,
    output logic       ok,
    output logic       bad
);
    feed_state_e st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            F_IDLE:  if (feed_wr && key == KEY_FIRST) st_nxt = F_ARMED;
            F_ARMED: if (access) st_nxt = F_IDLE;
            default: st_nxt = F_IDLE;
        endcase
    end

    always_comb begin
        ok  = 1'b0;
        bad = 1'b0;
        unique case (st)
            F_IDLE:  bad = feed_wr && (key != KEY_FIRST);
            F_ARMED: begin
                ok  = feed_wr && (key == KEY_SECOND);
                bad = access && !(feed_wr && (key == KEY_SECOND));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int INIT  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rst_mode,
    input  logic             feed_ok,
    input  logic             feed_bad,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             expire,
    output logic             irq,
    output logic             rst_req
);
    wdt_state_e st, st_nxt;
    logic load, dec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        load   = 1'b0;
        dec    = 1'b0;
        unique case (st)
            S_OFF: if (en) st_nxt = S_WAIT;
            S_WAIT: begin
                if (feed_bad) st_nxt = S_EXPIRED;
                else if (feed_ok) begin
                    st_nxt = S_RUN;
                    load   = 1'b1;
                end
            end
            S_RUN: begin
                if (feed_bad)      st_nxt = S_EXPIRED;
                else if (feed_ok)  load   = 1'b1;
                else if (tick) begin
                    if (count == '0) st_nxt = S_EXPIRED;
                    else             dec    = 1'b1;
                end
            end
            S_EXPIRED: begin
                if (!rst_mode && feed_ok) begin
                    st_nxt = S_RUN;
                    load   = 1'b1;
                end
            end
            default: st_nxt = S_OFF;
        endcase
    end

    always_comb begin
        run     = (st == S_RUN);
        expire  = (st_nxt == S_EXPIRED) && (st != S_EXPIRED);
        irq     = (st == S_EXPIRED) && !rst_mode;
        rst_req = (st == S_EXPIRED) && rst_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= CNT_W'(INIT);
        else if (load) count <= reload;
        else if (dec)  count <= count - 1'b1;
    end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int MIN_RELOAD = 255,
    parameter int DIV        = 4
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        tick_rtc,
    input  logic        tick_irc,
    input  logic        tick_en,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_rst_req,
    output logic        wdt_flag
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);
    localparam int SEL_W = 2;

    logic             en_q, rmode_q, flag_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] reload_q, count;
    logic             wr_mode, wr_reload, feed_wr, access;
    logic             feed_ok, feed_bad, pulse, run, expire;

    assign access    = bus_wr || bus_rd;
    assign wr_mode   = bus_wr && (bus_addr == A_MODE);
    assign wr_reload = bus_wr && (bus_addr == A_RELOAD);
    assign feed_wr   = bus_wr && (bus_addr == A_FEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rmode_q  <= 1'b0;
            sel_q    <= '0;
            reload_q <= FLOOR;
        end else begin
            if (wr_mode) begin
                en_q    <= en_q | bus_wdata[B_EN];
                rmode_q <= rmode_q | bus_wdata[B_RMODE];
                sel_q   <= bus_wdata[B_SEL +: SEL_W];
            end
            if (wr_reload)
                reload_q <= (bus_wdata[CNT_W-1:0] < FLOOR) ? FLOOR : bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                          flag_q <= 1'b0;
        else if (expire)                     flag_q <= 1'b1;
        else if (wr_mode && bus_wdata[B_FLAG]) flag_q <= 1'b0;
    end

    wdt_feed u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (access),
        .feed_wr (feed_wr),
        .key     (bus_wdata[7:0]),
        .ok      (feed_ok),
        .bad     (feed_bad)
    );

    wdt_prescale #(.NSRC(2), .SEL_W(SEL_W), .DIV(DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick ({tick_irc, tick_rtc}),
        .sel      (sel_q),
        .tick_en  (tick_en),
        .run      (run),
        .clr      (feed_ok),
        .pulse    (pulse)
    );

    wdt_ctrl #(.CNT_W(CNT_W), .INIT(MIN_RELOAD)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .rst_mode (rmode_q),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad && en_q),
        .tick     (pulse),
        .reload   (reload_q),
        .count    (count),
        .run      (run),
        .expire   (expire),
        .irq      (wdt_irq),
        .rst_req  (wdt_rst_req)
    );

    assign wdt_flag = flag_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MODE:   bus_rdata = {27'd0, sel_q, flag_q, rmode_q, en_q};
            A_RELOAD: bus_rdata = 32'(reload_q);
            A_FEED:   bus_rdata = '0;
            A_COUNT:  bus_rdata = 32'(count);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva #(
    parameter int CNT_W      = 32,
    parameter int MIN_RELOAD = 255
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rst_req,
    input logic             flag,
    input logic             en,
    input logic             rmode,
    input logic             run,
    input logic             feed_ok,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count
);
    p_reload_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload >= CNT_W'(MIN_RELOAD));

    p_en_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);

    p_rmode_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rmode |=> rmode);

    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !feed_ok) |=> $stable(count));

    p_one_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && rst_req));

    p_action_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || rst_req) |-> en);

    p_flag_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) || $rose(rst_req)) |-> flag);

    p_rst_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind wdt_top wdt_sva #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (wdt_irq),
    .rst_req (wdt_rst_req),
    .flag    (wdt_flag),
    .en      (en_q),
    .rmode   (rmode_q),
    .run     (run),
    .feed_ok (feed_ok),
    .reload  (reload_q),
    .count   (count)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        tick_rtc = 1'b0, tick_irc = 1'b0, tick_en = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, wdt_rst_req, wdt_flag;

    int unsigned cyc = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    typedef struct { int unsigned at; bit is_rst; } evt_t;
    evt_t exp_q[$];

    wdt_top u_dut (.*);

    always #2.5ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1ns d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic feed();
        @(negedge clk); bus_addr = 2'd2; bus_wdata = 32'hAA; bus_wr = 1'b1;
        @(negedge clk); bus_wdata = 32'h55;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_evt(input int unsigned at, input bit is_rst);
        evt_t e;
        e.at = at; e.is_rst = is_rst;
        exp_q.push_back(e);
    endtask

    // monitor: every rising action is popped and compared
    logic irq_d = 1'b0, rst_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && ((wdt_irq && !irq_d) || (wdt_rst_req && !rst_d))) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 unexpected expiry actual=%0d expected=none", cyc);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                chk("R6 expiry cycle", cyc, e.at);
                chk("R6 action kind", {31'd0, wdt_rst_req}, {31'd0, e.is_rst});
            end
        end
        irq_d = wdt_irq;
        rst_d = wdt_rst_req;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unsigned f, t;
        idle(4);
        por_n = 1'b1; rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, d); chk("R1 mode", d, 32'h0);
        rd(2'd1, d); chk("R1 reload", d, 32'hFF);
        rd(2'd3, d); chk("R1 count", d, 32'hFF);
        chk("R1 outputs", {29'd0, wdt_irq, wdt_rst_req, wdt_flag}, 32'h0);

        // R2 reload floor
        wr(2'd1, 32'h10);  rd(2'd1, d); chk("R2 clamp", d, 32'hFF);
        wr(2'd1, 32'h300); rd(2'd1, d); chk("R2 keep", d, 32'h300);

        // R4 no counting before enable and feed
        wr(2'd0, 32'h10); idle(20);
        rd(2'd3, d); chk("R4 disabled", d, 32'hFF);
        wr(2'd0, 32'h11); idle(20);
        rd(2'd3, d); chk("R4 unfed", d, 32'hFF);
        // R3 enable cannot be cleared
        wr(2'd0, 32'h10); rd(2'd0, d); chk("R3 enable sticky", d, 32'h11);

        // R5 / R6 first period
        feed(); f = cyc;
        expect_evt(f + 4 * (32'h300 + 1), 1'b0);
        rd(2'd3, d); chk("R5 loaded", d, 32'h300);
        while (cyc < f + 4 * (32'h300 + 1) + 2) @(negedge clk);
        chk("R6 irq", {31'd0, wdt_irq}, 32'd1);
        chk("R8 flag set", {31'd0, wdt_flag}, 32'd1);

        // R10 recovery, then R12 collision of feed and final tick
        wr(2'd1, 32'h100);
        feed(); f = cyc;
        chk("R10 irq cleared", {31'd0, wdt_irq}, 32'd0);
        t = f + 4 * (32'h100 + 1);
        while (cyc != t - 3) @(negedge clk);
        feed();
        chk("R12 feed edge", cyc, t);
        expect_evt(t + 4 * (32'h100 + 1), 1'b0);
        while (cyc < t + 4 * (32'h100 + 1) + 2) @(negedge clk);
        chk("R12 later expiry", {31'd0, wdt_irq}, 32'd1);

        // R8 write-one clear
        wr(2'd0, 32'h15); rd(2'd0, d); chk("R8 w1c", d, 32'h11);

        // R9 tick gating and source selection
        tick_en = 1'b0;
        feed(); idle(40);
        rd(2'd3, d); chk("R9 tick_en low", d, 32'h100);
        tick_en = 1'b1;
        wr(2'd0, 32'h01); idle(40);
        rd(2'd3, d); chk("R9 strobe 0 low", d, 32'h100);
        tick_irc = 1'b1;
        wr(2'd0, 32'h09); idle(40);
        rd(2'd3, d); chk("R9 strobe 1 runs", {31'd0, d < 32'h100}, 32'd1);

        // R7 key broken by a read
        wr(2'd2, 32'hAA);
        expect_evt(cyc + 2, 1'b0);
        rd(2'd0, d); idle(2);
        chk("R7 broken by read", {31'd0, wdt_irq}, 32'd1);
        feed(); chk("R7 recovered", {31'd0, wdt_irq}, 32'd0);
        wr(2'd0, 32'h11);
        expect_evt(cyc + 2, 1'b0);
        wr(2'd2, 32'h12); idle(2);
        chk("R7 bad key", {31'd0, wdt_irq}, 32'd1);

        // R11 reset mode
        feed();
        wr(2'd0, 32'h13);
        wr(2'd0, 32'h11); rd(2'd0, d); chk("R3 rmode sticky", d & 32'h3, 32'h3);
        expect_evt(cyc + 2, 1'b1);
        wr(2'd2, 32'h00); idle(10);
        chk("R11 request held", {30'd0, wdt_rst_req, wdt_irq}, 32'h2);
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(2);
        chk("R11 released", {31'd0, wdt_rst_req}, 32'd0);
        rd(2'd0, d); chk("R8 flag kept over reset", d, 32'h04);
        por_n = 1'b0; idle(2); por_n = 1'b1; idle(2);
        chk("R8 por clears", {31'd0, wdt_flag}, 32'd0);

        chk("R6 all expiries seen", exp_q.size(), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule